// File: doc/BRIEF.md
# Serial Flash Command Framer

This block is the serial slave front end of a NOR flash model. It watches a chip-select, a serial clock and a serial data input. All three are already synchronous to the system clock, and the block finds their edges itself. It builds bytes from the data line, most significant bit first, and treats the first byte of each selection as the command code. It then counts the address bytes and data bytes that follow. For commands that return data, it fetches bytes from a downstream source through an address/data pair and shifts them out on a serial output. It changes that output on falling serial clock edges.

Write-type commands are never carried out while the bus is active. When chip-select rises, the block checks two things: that the clock count is a whole number of bytes, and that the byte count fits the command. Only if both hold does it issue a single-cycle execute strobe. The strobe carries the command code, the address and the number of data bytes. Program and status-write data bytes are streamed out one by one as they complete. The downstream logic keeps them only if the execute strobe follows. Reads may be cut off after any bit. Unknown codes leave the block silent until the next selection.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After synchronous reset, `exec_o`, `dat_valid_o` and `so_oe_o` are 0 and `so_o` is 1.
- R2: A data bit is taken from `si_i` on each rising serial clock while `csn_i` is low, MSB first. A data byte of a page program (code 02h, fifth byte onward) or of a status write (code 01h, second byte only) appears on `dat_o`, with `dat_valid_o` high for one cycle, one clock after the cycle in which its eighth rising edge is detected.
- R3: Commands with an address (02h, 20h, D8h, 03h, 0Bh) take three address bytes after the code, most significant byte first. `exec_addr_o` reports that address.
- R4: `exec_o` pulses for one cycle, one clock after the cycle in which `csn_i` is seen rising, for a write-type command whose byte count fits it. The fits are: 06h, 04h, C7h and 60h exactly 1 byte; 20h and D8h exactly 4 bytes; 01h exactly 2 bytes; 02h at least 5 bytes.
- R5: A write-type command whose serial clock count at deselection is not a multiple of eight gives no `exec_o`. This includes a page program with a trailing partial byte.
- R6: `exec_cnt_o` equals the number of bytes after the code and address, and `exec_op_o` equals the command code.
- R7: For read status (05h) and read ID (9Fh), output begins on the falling edge after the eighth clock. `so_oe_o` goes high and the bytes leave MSB first, each bit changing only on a falling serial clock.
- R8: For read (03h), output begins after 32 clocks. `rd_addr_o` equals the received address for the first byte and increases by one for each further byte, wrapping at 24 bits. For 05h and 9Fh it counts from 0.
- R9: For fast read (0Bh), one dummy byte follows the address, so output begins after 40 clocks.
- R10: A read may be deselected after any bit. `so_oe_o` falls one clock after `csn_i` is seen high, and no `exec_o` results.
- R11: An unknown code produces no `exec_o` and no `dat_valid_o`, and `so_oe_o` stays 0 until the next selection.
- R12: Read-type commands never produce `exec_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock, synchronous to clk |
| csn_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (0 = high impedance) |
| rd_addr_o | output | 24 | Address of the byte to be sent next |
| rd_data_i | input | 8 | Byte at rd_addr_o, supplied by downstream logic |
| dat_o | output | 8 | Completed write data byte |
| dat_valid_o | output | 1 | One-cycle strobe for dat_o |
| exec_o | output | 1 | One-cycle execute strobe for a valid write command |
| exec_op_o | output | 8 | Command code carried by the strobe |
| exec_addr_o | output | 24 | Address carried by the strobe |
| exec_cnt_o | output | 10 | Data byte count carried by the strobe |

## Verification
A data byte strobe and the serial-out bit that follows a falling edge are both due one clock after the cycle in which the block sees the serial clock edge. The execute strobe and the drop of the output enable are due one clock after the cycle in which chip-select is seen high. The bench keeps a behavioural model that reacts to the same input samples at the same rising clock edge. The model produces its expected values with that one-clock delay, and every output is compared against it on the falling system clock edge, well away from the edge where both update. Each transfer also ends with counted totals of execute and data strobes, read after the bus has been idle for several cycles.

// File: rtl/sfe_pkg.sv
// Package: command codes and per-command framing attributes shared by the
// framer, the transmit shifter and the commit stage.
package sfe_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_SE    = 8'h20;
    localparam logic [7:0] OP_BE    = 8'hD8;
    localparam logic [7:0] OP_CE_A  = 8'hC7;
    localparam logic [7:0] OP_CE_B  = 8'h60;
    localparam logic [7:0] OP_RDID  = 8'h9F;

    // Framing attributes of one command code.
    typedef struct packed {
        logic is_write;  // committed only at deselection
        logic is_read;   // has a data-out phase
        logic has_addr;  // address bytes follow the code
        logic dummy;     // one dummy byte before data out
        logic has_data;  // at least one data byte required
        logic exact;     // byte count must match exactly
    } cmd_info_t;

    // Map a command code to its framing attributes; unknown codes give all zero.
    function automatic cmd_info_t decode_op(input logic [7:0] op);
        cmd_info_t info;
        info = '0;
        case (op)
            OP_WREN, OP_WRDI, OP_CE_A, OP_CE_B: begin
                info.is_write = 1'b1;
                info.exact    = 1'b1;
            end
            OP_SE, OP_BE: begin
                info.is_write = 1'b1;
                info.has_addr = 1'b1;
                info.exact    = 1'b1;
            end
            OP_WRSR: begin
                info.is_write = 1'b1;
                info.has_data = 1'b1;
                info.exact    = 1'b1;
            end
            OP_PP: begin
                info.is_write = 1'b1;
                info.has_addr = 1'b1;
                info.has_data = 1'b1;
            end
            OP_RDSR, OP_RDID: begin
                info.is_read  = 1'b1;
            end
            OP_READ: begin
                info.is_read  = 1'b1;
                info.has_addr = 1'b1;
            end
            OP_FAST: begin
                info.is_read  = 1'b1;
                info.has_addr = 1'b1;
                info.dummy    = 1'b1;
            end
            default: info = '0;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/sfe_edge_det.sv
// Edge detector: finds rising and falling serial clock edges while the
// device is selected, and the rising edge of chip-select.
// Assumes sclk_i and csn_i are already synchronous to clk and that each
// serial clock phase lasts at least two system clocks.
module sfe_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic csn_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic cs_rise_o
);

    logic sclk_q;
    logic csn_q;

    // Keep last-cycle copies of serial clock and chip-select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_i;
            csn_q  <= csn_i;
        end
    end

    assign sclk_rise_o = !csn_i &&  sclk_i && !sclk_q;
    assign sclk_fall_o = !csn_i && !sclk_i &&  sclk_q;
    assign cs_rise_o   =  csn_i && !csn_q;

endmodule

// File: rtl/sfe_rx_framer.sv
// Receive framer: shifts in SI on rising serial clock edges, MSB first,
// counts bits and bytes since selection, captures the command code and
// the address, and streams write data bytes. All counters clear while
// chip-select is high. The byte count saturates at its maximum.
module sfe_rx_framer
    import sfe_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csn_i,
    input  logic                    si_i,
    input  logic                    sclk_rise_i,
    output logic [2:0]              bitcnt_o,
    output logic [CNT_W-1:0]        bytecnt_o,
    output logic [7:0]              opcode_o,
    output logic [8*ADDR_BYTES-1:0] addr_o,
    output logic [7:0]              dat_o,
    output logic                    dat_valid_o
);

    localparam int               ADDR_W = 8 * ADDR_BYTES;
    localparam logic [CNT_W-1:0] AB_C   = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] HDR_A  = CNT_W'(1 + ADDR_BYTES);

    logic [2:0]        bitcnt_q;
    logic [CNT_W-1:0]  bytecnt_q;
    logic [6:0]        sh_q;
    logic [7:0]        opcode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        dat_q;
    logic              dat_valid_q;

    logic [7:0]       byte_next;
    logic             byte_done;
    cmd_info_t        info;
    logic [CNT_W-1:0] hdr;
    logic [CNT_W-1:0] need;
    logic             take_data;
    logic             take_addr;

    // Next byte value, completion flag and the data/address capture conditions.
    always_comb begin
        byte_next = {sh_q, si_i};
        byte_done = sclk_rise_i && (bitcnt_q == 3'd7);
        info      = decode_op(opcode_q);
        hdr       = info.has_addr ? HDR_A : CNT_W'(1);
        need      = hdr + CNT_W'(info.has_data);
        take_addr = byte_done && (bytecnt_q != '0) && info.has_addr
                    && (bytecnt_q <= AB_C);
        take_data = byte_done && (bytecnt_q != '0) && info.has_data
                    && (bytecnt_q >= hdr) && (!info.exact || bytecnt_q < need);
    end

    // Bit and byte counters, cleared whenever the device is deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q  <= '0;
            bytecnt_q <= '0;
            sh_q      <= '0;
        end else if (csn_i) begin
            bitcnt_q  <= '0;
            bytecnt_q <= '0;
        end else if (sclk_rise_i) begin
            sh_q     <= byte_next[6:0];
            bitcnt_q <= bitcnt_q + 3'd1;
            if (byte_done && bytecnt_q != '1) begin
                bytecnt_q <= bytecnt_q + CNT_W'(1);
            end
        end
    end

    // Capture the command code and the address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q <= '0;
            addr_q   <= '0;
        end else if (!csn_i) begin
            if (byte_done && bytecnt_q == '0) begin
                opcode_q <= byte_next;
            end
            if (take_addr) begin
                addr_q <= {addr_q[ADDR_W-9:0], byte_next};
            end
        end
    end

    // Emit each completed write data byte as a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q       <= '0;
            dat_valid_q <= 1'b0;
        end else begin
            dat_valid_q <= !csn_i && take_data;
            if (!csn_i && take_data) begin
                dat_q <= byte_next;
            end
        end
    end

    assign bitcnt_o    = bitcnt_q;
    assign bytecnt_o   = bytecnt_q;
    assign opcode_o    = opcode_q;
    assign addr_o      = addr_q;
    assign dat_o       = dat_q;
    assign dat_valid_o = dat_valid_q;

    // R2: a data strobe never lasts two cycles.
    a_r2_dv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid_q |=> !dat_valid_q);

    // R11: data strobes come only from write-type commands.
    a_r11_dv_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid_q |-> decode_op(opcode_q).is_write);

endmodule

// File: rtl/sfe_tx_shifter.sv
// Transmit shifter: for read-type commands, loads a byte from the
// downstream source at each byte boundary of the output phase and shifts
// it out MSB first, changing SO only on falling serial clock edges.
// Assumes rd_data_i is valid for rd_addr_o in the same cycle.
module sfe_tx_shifter
    import sfe_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csn_i,
    input  logic                    sclk_fall_i,
    input  logic [2:0]              bitcnt_i,
    input  logic [CNT_W-1:0]        bytecnt_i,
    input  logic [7:0]              opcode_i,
    input  logic [8*ADDR_BYTES-1:0] addr_i,
    input  logic [7:0]              rd_data_i,
    output logic [8*ADDR_BYTES-1:0] rd_addr_o,
    output logic                    so_o,
    output logic                    so_oe_o
);

    localparam int               ADDR_W = 8 * ADDR_BYTES;
    localparam logic [CNT_W-1:0] AB_C   = CNT_W'(ADDR_BYTES);

    logic              so_q;
    logic              so_oe_q;
    logic [7:0]        sh_q;
    logic [ADDR_W-1:0] off_q;

    cmd_info_t        info;
    logic [CNT_W-1:0] start;
    logic             load;

    // Decide where the output phase starts and when a new byte is loaded.
    always_comb begin
        info  = decode_op(opcode_i);
        start = CNT_W'(1) + (info.has_addr ? AB_C : '0) + CNT_W'(info.dummy);
        load  = sclk_fall_i && info.is_read && (bytecnt_i != '0)
                && (bitcnt_i == 3'd0) && (bytecnt_i >= start);
    end

    // Output shift register, enable and byte offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so_q    <= 1'b1;
            so_oe_q <= 1'b0;
            sh_q    <= '0;
            off_q   <= '0;
        end else if (csn_i) begin
            so_q    <= 1'b1;
            so_oe_q <= 1'b0;
            off_q   <= '0;
        end else if (load) begin
            so_q    <= rd_data_i[7];
            sh_q    <= {rd_data_i[6:0], 1'b0};
            so_oe_q <= 1'b1;
            off_q   <= off_q + ADDR_W'(1);
        end else if (sclk_fall_i && so_oe_q) begin
            so_q <= sh_q[7];
            sh_q <= {sh_q[6:0], 1'b0};
        end
    end

    assign rd_addr_o = (info.has_addr ? addr_i : '0) + off_q;
    assign so_o      = so_q;
    assign so_oe_o   = so_oe_q;

    // R10: deselection removes the output drive on the next clock.
    a_r10_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
        csn_i |=> !so_oe_q);

    // R11: only read-type commands drive SO.
    a_r11_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe_q |-> decode_op(opcode_i).is_read);

    // R7: SO holds between falling serial clock edges.
    a_r7_so_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe_q && !sclk_fall_i && !csn_i) |=> $stable(so_q));

endmodule

// File: rtl/sfe_commit.sv
// Commit stage: at chip-select rise, accepts a write-type command only if
// the clock count is a whole number of bytes and the byte count fits the
// command, then emits a one-cycle execute strobe with code, address and
// data byte count. Relies on the framer counters still holding their
// values in the cycle where chip-select is first seen high.
module sfe_commit
    import sfe_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_rise_i,
    input  logic [2:0]              bitcnt_i,
    input  logic [CNT_W-1:0]        bytecnt_i,
    input  logic [7:0]              opcode_i,
    input  logic [8*ADDR_BYTES-1:0] addr_i,
    output logic                    exec_o,
    output logic [7:0]              exec_op_o,
    output logic [8*ADDR_BYTES-1:0] exec_addr_o,
    output logic [CNT_W-1:0]        exec_cnt_o
);

    localparam int               ADDR_W = 8 * ADDR_BYTES;
    localparam logic [CNT_W-1:0] HDR_A  = CNT_W'(1 + ADDR_BYTES);

    logic              exec_q;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    cmd_info_t        info;
    logic [CNT_W-1:0] hdr;
    logic [CNT_W-1:0] need;
    logic             len_ok;
    logic             accept;

    // Length and alignment check of the finished command.
    always_comb begin
        info   = decode_op(opcode_i);
        hdr    = info.has_addr ? HDR_A : CNT_W'(1);
        need   = hdr + CNT_W'(info.has_data);
        len_ok = info.exact ? (bytecnt_i == need) : (bytecnt_i >= need);
        accept = cs_rise_i && info.is_write && (bitcnt_i == 3'd0)
                 && (bytecnt_i != '0) && len_ok;
    end

    // Register the execute strobe and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q <= 1'b0;
            op_q   <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            exec_q <= accept;
            if (accept) begin
                op_q   <= opcode_i;
                addr_q <= addr_i;
                cnt_q  <= bytecnt_i - hdr;
            end
        end
    end

    assign exec_o      = exec_q;
    assign exec_op_o   = op_q;
    assign exec_addr_o = addr_q;
    assign exec_cnt_o  = cnt_q;

    // R4: the strobe follows a chip-select rise by one clock.
    a_r4_exec_after_csrise: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |-> $past(cs_rise_i));

    // R4: the strobe is a single-cycle pulse.
    a_r4_exec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |=> !exec_q);

    // R5: only byte-aligned deselection commits.
    a_r5_exec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |-> ($past(bitcnt_i) == 3'd0));

    // R12: reads and unknown codes never commit.
    a_r12_exec_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |-> decode_op(op_q).is_write);

endmodule

// File: rtl/spi_cmd_frontend.sv
// Top: serial command framer of a flash model. Connects the edge detector,
// the receive framer, the transmit shifter and the commit stage.
// Assumes all serial inputs are synchronous to clk and each serial clock
// phase lasts at least two clk cycles.
module spi_cmd_frontend #(
    parameter int CNT_W      = 10,
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk_i,
    input  logic                    csn_i,
    input  logic                    si_i,
    output logic                    so_o,
    output logic                    so_oe_o,
    output logic [8*ADDR_BYTES-1:0] rd_addr_o,
    input  logic [7:0]              rd_data_i,
    output logic [7:0]              dat_o,
    output logic                    dat_valid_o,
    output logic                    exec_o,
    output logic [7:0]              exec_op_o,
    output logic [8*ADDR_BYTES-1:0] exec_addr_o,
    output logic [CNT_W-1:0]        exec_cnt_o
);

    localparam int ADDR_W = 8 * ADDR_BYTES;

    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_rise;
    logic [2:0]        bitcnt;
    logic [CNT_W-1:0]  bytecnt;
    logic [7:0]        opcode;
    logic [ADDR_W-1:0] addr;

    sfe_edge_det u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .csn_i       (csn_i),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .cs_rise_o   (cs_rise)
    );

    sfe_rx_framer #(.CNT_W(CNT_W), .ADDR_BYTES(ADDR_BYTES)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .csn_i       (csn_i),
        .si_i        (si_i),
        .sclk_rise_i (sclk_rise),
        .bitcnt_o    (bitcnt),
        .bytecnt_o   (bytecnt),
        .opcode_o    (opcode),
        .addr_o      (addr),
        .dat_o       (dat_o),
        .dat_valid_o (dat_valid_o)
    );

    sfe_tx_shifter #(.CNT_W(CNT_W), .ADDR_BYTES(ADDR_BYTES)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .csn_i       (csn_i),
        .sclk_fall_i (sclk_fall),
        .bitcnt_i    (bitcnt),
        .bytecnt_i   (bytecnt),
        .opcode_i    (opcode),
        .addr_i      (addr),
        .rd_data_i   (rd_data_i),
        .rd_addr_o   (rd_addr_o),
        .so_o        (so_o),
        .so_oe_o     (so_oe_o)
    );

    sfe_commit #(.CNT_W(CNT_W), .ADDR_BYTES(ADDR_BYTES)) u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_rise_i   (cs_rise),
        .bitcnt_i    (bitcnt),
        .bytecnt_i   (bytecnt),
        .opcode_i    (opcode),
        .addr_i      (addr),
        .exec_o      (exec_o),
        .exec_op_o   (exec_op_o),
        .exec_addr_o (exec_addr_o),
        .exec_cnt_o  (exec_cnt_o)
    );

endmodule

// File: tb/test_spi_cmd_frontend.sv
// Bench: drives serial transfers and compares every output against a
// behavioural model on each falling system clock edge.
module test_spi_cmd_frontend;

    localparam int CNT_W = 10;
    localparam int HALF  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        csn = 1'b1;
    logic        si = 1'b0;
    logic        so, so_oe, dat_valid, exec_p;
    logic [23:0] rd_addr, exec_addr;
    logic [7:0]  rd_data, dat, exec_op;
    logic [CNT_W-1:0] exec_cnt;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    // Downstream data source: a fixed function of the address.
    function automatic logic [7:0] pat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction
    assign rd_data = pat(rd_addr);

    spi_cmd_frontend i_spi_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .si_i(si),
        .so_o(so), .so_oe_o(so_oe), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .dat_o(dat), .dat_valid_o(dat_valid), .exec_o(exec_p),
        .exec_op_o(exec_op), .exec_addr_o(exec_addr), .exec_cnt_o(exec_cnt)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_nclk, m_loads, m_idx, m_st, m_nb;
    logic [7:0]  m_cur, m_osh, m_d, m_op;
    logic [7:0]  m_bytes[$];
    logic        m_psclk, m_pcsn, m_ok;
    logic        e_exec, e_dv, e_oe, e_so, e_hasaddr;
    logic [7:0]  e_op, e_dat;
    logic [23:0] e_addr;
    int          e_cnt;

    function automatic logic [23:0] m_addr();
        if (m_bytes.size() >= 4) return {m_bytes[1], m_bytes[2], m_bytes[3]};
        return 24'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_nclk = 0; m_loads = 0; m_cur = 0; m_osh = 0;
            m_bytes.delete();
            m_psclk = 1'b0; m_pcsn = 1'b1;
            e_exec = 0; e_dv = 0; e_oe = 0; e_so = 1; e_dat = 0;
            e_op = 0; e_addr = 0; e_cnt = 0; e_hasaddr = 0;
        end else begin
            e_exec = 0;
            e_dv   = 0;
            if (!csn && sclk && !m_psclk) begin
                m_nclk++;
                m_cur = {m_cur[6:0], si};
                if (m_nclk % 8 == 0) begin
                    m_idx = m_bytes.size();
                    m_bytes.push_back(m_cur);
                    if (m_idx > 0 && ((m_bytes[0] == 8'h02 && m_idx >= 4) ||
                                      (m_bytes[0] == 8'h01 && m_idx == 1))) begin
                        e_dv  = 1;
                        e_dat = m_cur;
                    end
                end
            end
            if (!csn && !sclk && m_psclk) begin
                m_st = -1;
                if (m_bytes.size() > 0) begin
                    case (m_bytes[0])
                        8'h05, 8'h9F: m_st = 1;
                        8'h03:        m_st = 4;
                        8'h0B:        m_st = 5;
                        default:      m_st = -1;
                    endcase
                end
                if (m_st > 0 && m_nclk % 8 == 0 && m_nclk / 8 >= m_st) begin
                    m_d = (m_bytes[0] == 8'h03 || m_bytes[0] == 8'h0B)
                          ? pat(m_addr() + 24'(m_loads)) : pat(24'(m_loads));
                    m_loads++;
                    e_oe  = 1;
                    e_so  = m_d[7];
                    m_osh = {m_d[6:0], 1'b0};
                end else if (e_oe) begin
                    e_so  = m_osh[7];
                    m_osh = {m_osh[6:0], 1'b0};
                end
            end
            if (csn && !m_pcsn) begin
                m_nb = m_nclk / 8;
                m_ok = 0;
                if (m_nclk > 0 && m_nclk % 8 == 0) begin
                    m_op = m_bytes[0];
                    case (m_op)
                        8'h06, 8'h04, 8'hC7, 8'h60: m_ok = (m_nb == 1);
                        8'h20, 8'hD8:               m_ok = (m_nb == 4);
                        8'h01:                      m_ok = (m_nb == 2);
                        8'h02:                      m_ok = (m_nb >= 5);
                        default:                    m_ok = 0;
                    endcase
                    if (m_ok) begin
                        e_exec    = 1;
                        e_op      = m_op;
                        e_hasaddr = (m_op == 8'h20 || m_op == 8'hD8 || m_op == 8'h02);
                        e_addr    = m_addr();
                        e_cnt     = (m_op == 8'h02) ? m_nb - 4 : (m_op == 8'h01 ? 1 : 0);
                    end
                end
            end
            if (csn) begin
                m_nclk = 0; m_loads = 0;
                m_bytes.delete();
                e_oe = 0; e_so = 1;
            end
            m_psclk = sclk;
            m_pcsn  = csn;
        end
    end

    // Per-cycle comparison, away from the active edge; also strobe tallies.
    int exec_seen, dv_seen;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(exec_p == e_exec, "R4 R5 R12 exec_o", 32'(exec_p), 32'(e_exec));
            if (e_exec) begin
                chk(exec_op == e_op, "R6 exec_op_o", 32'(exec_op), 32'(e_op));
                chk(exec_cnt == CNT_W'(e_cnt), "R6 exec_cnt_o", 32'(exec_cnt), 32'(e_cnt));
                if (e_hasaddr)
                    chk(exec_addr == e_addr, "R3 exec_addr_o", 32'(exec_addr), 32'(e_addr));
            end
            chk(dat_valid == e_dv, "R2 dat_valid_o", 32'(dat_valid), 32'(e_dv));
            if (e_dv) chk(dat == e_dat, "R2 dat_o", 32'(dat), 32'(e_dat));
            chk(so_oe == e_oe, "R7 R10 R11 so_oe_o", 32'(so_oe), 32'(e_oe));
            if (e_oe) chk(so == e_so, "R7 R8 R9 so_o", 32'(so), 32'(e_so));
            if (exec_p) exec_seen++;
            if (dat_valid) dv_seen++;
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] tx_q[$];

    task automatic xfer(input int nbits, input int n_exec, input int n_dv,
                        input string tag);
        exec_seen = 0;
        dv_seen   = 0;
        @(negedge clk) csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            si = (i / 8 < tx_q.size()) ? tx_q[i / 8][7 - (i % 8)] : 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (6) @(negedge clk);
        chk(exec_seen == n_exec, {tag, " exec count"}, 32'(exec_seen), 32'(n_exec));
        chk(dv_seen == n_dv, {tag, " data strobe count"}, 32'(dv_seen), 32'(n_dv));
    endtask

    task automatic run_tests();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(exec_p == 1'b0 && dat_valid == 1'b0 && so_oe == 1'b0 && so == 1'b1,
            "R1 reset outputs", {28'h0, exec_p, dat_valid, so_oe, so}, 32'h1);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);

        tx_q = '{8'h06};                         xfer(8, 1, 0, "R4 write enable");
        tx_q = '{8'h06};                         xfer(9, 0, 0, "R5 write enable 9 clocks");
        tx_q = '{8'h04};                         xfer(8, 1, 0, "R4 write disable");
        tx_q = '{8'h20, 8'h12, 8'h34, 8'h56};    xfer(32, 1, 0, "R3 sector erase");
        tx_q = '{8'hD8, 8'hAB, 8'hCD};           xfer(24, 0, 0, "R4 short block erase");
        tx_q = '{8'hD8, 8'hAB, 8'hCD, 8'hEF};    xfer(32, 1, 0, "R3 block erase");
        tx_q = '{8'h02, 8'h00, 8'h10, 8'h20, 8'h11, 8'h22, 8'h33};
                                                 xfer(56, 1, 3, "R6 page program");
        tx_q = '{8'h02, 8'h00, 8'h10, 8'h20, 8'h11, 8'h22, 8'h33, 8'hF0};
                                                 xfer(61, 0, 3, "R5 program partial byte");
        tx_q = '{8'h02, 8'h00, 8'h10, 8'h20};    xfer(32, 0, 0, "R4 program without data");
        tx_q = '{8'h01, 8'h9C};                  xfer(16, 1, 1, "R2 status write");
        tx_q = '{8'h01, 8'h9C, 8'h00};           xfer(24, 0, 1, "R4 status write too long");
        tx_q = '{8'hC7};                         xfer(8, 1, 0, "R4 chip erase C7");
        tx_q = '{8'h60};                         xfer(8, 1, 0, "R4 chip erase 60");
        tx_q = '{8'h60, 8'h00};                  xfer(16, 0, 0, "R4 chip erase extra byte");
        tx_q = '{8'h05};                         xfer(24, 0, 0, "R7 R12 read status");
        tx_q = '{8'h9F};                         xfer(32, 0, 0, "R7 R8 read id");
        tx_q = '{8'h03, 8'h00, 8'hFF, 8'hFE};    xfer(59, 0, 0, "R8 R10 read cut mid bit");
        tx_q = '{8'h03, 8'hFF, 8'hFF, 8'hFF};    xfer(48, 0, 0, "R8 read address wrap");
        tx_q = '{8'h0B, 8'h12, 8'h34, 8'h56, 8'h00};
                                                 xfer(56, 0, 0, "R9 fast read");
        tx_q = '{8'h5A, 8'h02};                  xfer(24, 0, 0, "R11 unknown code");
        tx_q = '{8'h0B, 8'h12};                  xfer(13, 0, 0, "R10 read cut in address");
        tx_q = '{8'h06};                         xfer(0, 0, 0, "R5 empty selection");
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                tests++;
                $display("FAIL watchdog R1 actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule